// File: doc/BRIEF.md
# Framed Manchester Line Transmitter

This block turns a stream of 16-bit samples into a continuous Manchester-coded serial line signal, ready for a differential line driver. Every frame carries one sample: a long run of zero bits, then a single one bit that marks the frame start, then the sample itself, most significant bit first. The zero run is long enough that a receiver that loses alignment always finds the next start bit, because no data pattern can imitate the run.

The block runs from a clock at twice the bit rate, so 2 MHz for the nominal 1 Mbit/s line. Each bit period is two clock cycles. The bit-clock level and the current data bit are both taken from flip-flops. A third flip-flop combines them, so the line pin is driven straight from a register and carries no combinational glitch. A sample is taken once per frame, in the last clock cycle before the start bit. If no valid sample is offered in that cycle, the previous sample goes out again.

Top module: `manchester_frame_tx`

## Requirements
- R1: A frame is 48 bit periods and each bit period is two clock cycles. Bit positions 0 to 30 are zero, position 31 is the start bit of value 1, and positions 32 to 47 carry the held sample. Frames follow each other back to back with no gap.
- R2: The sample is sent most significant bit first. Position 32+i carries sample bit 15-i.
- R3: Each bit is Manchester coded as the bit-clock level XOR the data bit, with the clock level high in the first half. A 0 is sent as line 1 then 0, and a 1 as line 0 then 1. There is therefore always a line transition in the middle of a bit.
- R4: The line output comes from a register fed by registered copies of the clock level and the data bit. Define cycle m as the state after m rising edges since reset release, and state s = m-2. The output in cycle m is the coded level of half s%2 of bit position (s/2)%48 in frame s/96. The output is 0 in cycles 0 and 1.
- R5: Over every 96-cycle frame window of the output, starting at cycle 2, the line is high for exactly 48 cycles.
- R6: The sample-accept output is high only in cycles m with m%96 = 61, which is the second half of bit position 30. In those cycles it equals the sample-valid input, and the offered sample is latched at the next edge. Frame m/96 sends the latched sample.
- R7: If sample-valid is low in the latch cycle, the frame resends the previous sample. Sample data and sample-valid have no effect in any other cycle.
- R8: While reset is asserted (active low, asynchronous), the line output and sample-accept are 0. The frame restarts at position 0, first half, and the held sample is cleared to 0.
- R9: At least 18 zero bits come before every start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_data | input | 16 | Sample offered for the next frame |
| sample_valid | input | 1 | Sample data is valid |
| line_out | output | 1 | Manchester-coded line signal |
| sample_accept | output | 1 | One-cycle pulse when a sample is latched |

## Verification
The line output is due two edges after the sequencer state it encodes: one edge for the retiming registers and one for the output register. The bench therefore checks cycle m against the bit and half that its own model places at state m-2, sampling on the falling edge. Sample-accept is combinational from the sequencer state and sample-valid. It is checked 1 ns after the bench drives sample-valid, in every cycle, against the rule that only cycle 61 of each 96 may accept. The latched sample is first observed in the data half of the same frame, at cycle 66 (the first data half, position 32 from state 64), and the bench keeps one expected sample per frame to compare there.

// File: rtl/manchester_frame_tx_pkg.sv
package manchester_frame_tx_pkg;

  // Half of a bit period; the bit clock is high in the first half.
  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;

  // Bit-clock level belonging to a half-bit phase.
  function automatic logic bit_clock_level(half_e h);
    return (h == HALF_FIRST);
  endfunction

  // Next half-bit phase.
  function automatic half_e next_half(half_e h);
    return (h == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
  endfunction

endpackage

// File: rtl/mft_frame_seq.sv
module mft_frame_seq
  import manchester_frame_tx_pkg::*;
#(
  parameter int PRE_LEN   = 31,
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = PRE_LEN + 1 + DATA_W,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  output half_e            half_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             load_slot_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_PRE = IDX_W'(PRE_LEN - 1);

  half_e            half_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_FIRST;
      idx_q  <= '0;
    end else begin
      half_q <= next_half(half_q);
      if (half_q == HALF_SECOND) begin
        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign half_o      = half_q;
  assign bit_idx_o   = idx_q;
  assign load_slot_o = (idx_q == LAST_PRE) && (half_q == HALF_SECOND);

endmodule

// File: rtl/mft_sample_hold.sv
module mft_sample_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_slot,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_data,
  output logic [DATA_W-1:0] held_o,
  output logic              accept_o
);

  logic [DATA_W-1:0] held_q;
  logic              take;

  assign take = load_slot & sample_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (take) begin
      held_q <= sample_data;
    end
  end

  assign held_o   = held_q;
  assign accept_o = take;

endmodule

// File: rtl/mft_bit_select.sv
module mft_bit_select #(
  parameter int PRE_LEN   = 31,
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = PRE_LEN + 1 + DATA_W,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] held,
  output logic              bit_o
);

  // Value of frame position idx: zero run, start bit, then payload MSB first.
  function automatic logic frame_bit(logic [IDX_W-1:0] idx,
                                     logic [DATA_W-1:0] smp);
    int                pos;
    logic [DATA_W-1:0] sh;
    pos = int'(idx) - (PRE_LEN + 1);
    if (int'(idx) < PRE_LEN) return 1'b0;
    if (int'(idx) == PRE_LEN) return 1'b1;
    sh = smp << pos;
    return sh[DATA_W-1];
  endfunction

  assign bit_o = frame_bit(bit_idx, held);

endmodule

// File: rtl/mft_retime.sv
module mft_retime
  import manchester_frame_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  half_e half_i,
  input  logic  bit_i,
  output logic  bclk_q_o,
  output logic  dbit_q_o,
  output logic  line_o
);

  logic bclk_q;
  logic dbit_q;
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      dbit_q <= 1'b0;
      line_q <= 1'b0;
    end else begin
      bclk_q <= bit_clock_level(half_i);
      dbit_q <= bit_i;
      line_q <= bclk_q ^ dbit_q;
    end
  end

  assign bclk_q_o = bclk_q;
  assign dbit_q_o = dbit_q;
  assign line_o   = line_q;

endmodule

// File: rtl/manchester_frame_tx.sv
module manchester_frame_tx
  import manchester_frame_tx_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 31,
  parameter int MIN_PRE = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_data,
  input  logic              sample_valid,
  output logic              line_out,
  output logic              sample_accept
);

  localparam int FRAME_LEN = PRE_LEN + 1 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  // Internal events, named for the checker.
  half_e             half_w;
  logic [IDX_W-1:0]  bit_idx_w;
  logic              load_slot_w;
  logic [DATA_W-1:0] held_w;
  logic              cur_bit_w;
  logic              bclk_q_w;
  logic              dbit_q_w;

  mft_frame_seq #(
    .PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .half_o(half_w), .bit_idx_o(bit_idx_w), .load_slot_o(load_slot_w)
  );

  mft_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load_slot(load_slot_w), .sample_valid(sample_valid),
    .sample_data(sample_data), .held_o(held_w), .accept_o(sample_accept)
  );

  mft_bit_select #(
    .PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)
  ) u_sel (
    .bit_idx(bit_idx_w), .held(held_w), .bit_o(cur_bit_w)
  );

  mft_retime u_rt (
    .clk(clk), .rst_n(rst_n),
    .half_i(half_w), .bit_i(cur_bit_w),
    .bclk_q_o(bclk_q_w), .dbit_q_o(dbit_q_w), .line_o(line_out)
  );

endmodule

// File: rtl/manchester_frame_tx_checker.sv
module manchester_frame_tx_checker
  import manchester_frame_tx_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 31,
  parameter int MIN_PRE = 18,
  parameter int IDX_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic              sample_accept,
  input logic              line_out,
  input half_e             half_w,
  input logic [IDX_W-1:0]  bit_idx_w,
  input logic [DATA_W-1:0] held_w,
  input logic              cur_bit_w
);

  localparam int FRAME_LEN = PRE_LEN + 1 + DATA_W;

  logic [1:0] since_rst;
  logic [7:0] zero_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      zero_run  <= '0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      if (half_w == HALF_FIRST) begin
        if (cur_bit_w) zero_run <= '0;
        else if (zero_run != 8'hff) zero_run <= zero_run + 8'd1;
      end
    end
  end

  // R1: frame position stays inside the frame
  a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_idx_w) < FRAME_LEN);

  // R3: line changes in the middle of every bit
  a_r3_midbit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && half_w == HALF_SECOND) |-> (line_out != $past(line_out)));

  // R6: accept only in the latch slot and only with valid
  a_r6_accept_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sample_accept |-> (int'(bit_idx_w) == PRE_LEN - 1 && half_w == HALF_SECOND && sample_valid));

  // R7: held sample changes only after an accept
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_accept |=> $stable(held_w));

  // R9: enough zero bits before each start bit
  a_r9_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
    (half_w == HALF_FIRST && cur_bit_w && int'(bit_idx_w) == PRE_LEN)
      |-> (int'(zero_run) >= MIN_PRE));

endmodule

bind manchester_frame_tx manchester_frame_tx_checker #(
  .DATA_W(DATA_W), .PRE_LEN(PRE_LEN), .MIN_PRE(MIN_PRE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
  .sample_accept(sample_accept), .line_out(line_out),
  .half_w(half_w), .bit_idx_w(bit_idx_w), .held_w(held_w), .cur_bit_w(cur_bit_w)
);

// File: tb/manchester_frame_tx_bench.sv
`timescale 1ns/1ps
module manchester_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_CYC  = 96;
  localparam int LATCH_CYC  = 61;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sample_data = '0;
  logic        sample_valid = 1'b0;
  logic        line_out;
  logic        sample_accept;

  int checks = 0;
  int failures = 0;
  int m = 0;
  int ones = 0;
  logic [15:0] fsamp [0:63];
  bit          frepeat [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  manchester_frame_tx u_manchester_frame_tx (
    .clk(clk), .rst_n(rst_n), .sample_data(sample_data),
    .sample_valid(sample_valid), .line_out(line_out), .sample_accept(sample_accept)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, m, act, exp);
    end
  endtask

  // Expected line level in cycle mm from the framing rules.
  function automatic logic exp_line(int mm);
    int s, f, pos, h;
    logic b;
    if (mm < 2) return 1'b0;
    s = mm - 2; f = s / FRAME_CYC; pos = (s % FRAME_CYC) / 2; h = s % 2;
    if (pos < 31) b = 1'b0;
    else if (pos == 31) b = 1'b1;
    else b = fsamp[f][47 - pos];
    return (h == 0) ? ~b : b;
  endfunction

  function automatic string line_tag(int mm);
    int s, pos;
    s = mm - 2; pos = (s % FRAME_CYC) / 2;
    if (mm < 2) return "R4";
    if (pos <= 31) return "R1/R3";
    if (frepeat[s / FRAME_CYC]) return "R7/R2";
    return "R2/R3";
  endfunction

  // Drive one cycle; entered and left at a falling edge.
  task automatic step(bit v, logic [15:0] d);
    bit slot;
    check(line_out === exp_line(m), line_tag(m), line_out, exp_line(m));
    if (m >= 2) begin
      if ((m - 2) % FRAME_CYC == 0) ones = 0;
      ones += int'(line_out);
      if ((m - 2) % FRAME_CYC == FRAME_CYC - 1) check(ones == 48, "R5", ones, 48);
    end
    sample_valid = v; sample_data = d;
    #1;
    slot = (m % FRAME_CYC == LATCH_CYC);
    check(sample_accept === (slot & v), slot ? "R6" : "R7", sample_accept, slot & v);
    if (slot) begin
      frepeat[m / FRAME_CYC] = !v;
      fsamp[m / FRAME_CYC] = v ? d : ((m / FRAME_CYC) > 0 ? fsamp[m / FRAME_CYC - 1] : 16'h0);
    end
    @(posedge clk); m++;
    @(negedge clk);
  endtask

  task automatic run_frames(int nfr, bit directed);
    for (int c = 0; c < nfr * FRAME_CYC; c++) begin
      int f = m / FRAME_CYC;
      if (m % FRAME_CYC == LATCH_CYC) begin
        if (directed && f == 0) step(1'b1, 16'hFFFF);
        else if (directed && f == 1) step(1'b1, 16'h0000);
        else if (directed && f == 2) step(1'b1, 16'h8001);
        else if (directed && (f == 3 || f == 4)) step(1'b0, 16'h5A5A);
        else step(($urandom % 4) != 0, 16'($urandom));
      end else begin
        step(1'($urandom), 16'($urandom));
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample_valid = 1'b1; sample_data = 16'hBEEF;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(line_out === 1'b0, "R8", line_out, 0);
      check(sample_accept === 1'b0, "R8", sample_accept, 0);
      @(negedge clk);
    end
    for (int k = 0; k < 64; k++) begin fsamp[k] = '0; frepeat[k] = 1'b0; end
    rst_n = 1'b1; m = 0; ones = 0;
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    do_reset();
    run_frames(20, 1'b1);
    // mid-run reset, then a frame with no valid sample: held sample reads 0 (R8)
    do_reset();
    for (int c = 0; c < FRAME_CYC; c++) begin
      if (m % FRAME_CYC == LATCH_CYC) step(1'b0, 16'hFFFF);
      else step(1'($urandom), 16'($urandom));
    end
    run_frames(10, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog cycle=%0d actual=0 expected=1", m);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule